// File: doc/BRIEF.md
# Character-Cell Pixel Fetch and Serializer

This block feeds a raster display whose memory is arranged in character cells. In that layout the eight pixel rows of one cell sit at consecutive addresses. The block generates the addresses of the bytes that form each scanline and asks the memory for them at a rate set by the mode. Each returned byte is turned into a stream of logical colour indices at 1, 2 or 4 bits per pixel, and every pixel can be repeated horizontally.

A timing generator outside the block drives four signals: a frame-start pulse, a line-start pulse, a fetch window and a pixel window. The fetch window opens one memory slot of 8 clocks before the pixel window. The memory answers each request with a byte and a valid strobe. The reply must come before the pixel window uses that byte, which is 8 clocks after the request. Mapping colour indices to a palette belongs to the stage downstream.

Top module: `cellpix_fetch`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `fetch_req` is low and `color_idx` is 0.
- R2: `fetch_req` is high only while `fetch_win` is high. It rises on the first cycle of the window and then repeats every (80 / `bytes_per_line`) slots of 8 clocks.
- R3: Within a scanline, each request that is issued advances `fetch_addr` by 8.
- R4: When an address step reaches 0x8000 or more, `screen_size` is subtracted, so every requested address stays below 0x8000.
- R5: A `line_start` that falls inside a character row sets the address to the row base plus the line number within the row, which runs from 0 to 7.
- R6: After the eighth line of a row, the next `line_start` moves the row base forward by `bytes_per_line` × 8 and resets the line number to 0. The wrap rule of R4 applies to this step.
- R7: `frame_start` loads `start_addr` as both the row base and the current address, with line number 0. It takes priority over a `line_start` in the same cycle.
- R8: `depth_sel` 0, 1 and 2 select 1, 2 and 4 bits per pixel, so each byte gives 8, 4 or 2 pixels. The most significant pixel comes out first, and the remaining code is treated as 1 bit per pixel.
- R9: Each pixel is held for `x_scale` clock cycles. A value of 0 behaves as 1.
- R10: On the first cycle of the pixel window, the serializer restarts at pixel 0 of the most recently received byte. The colour of that pixel appears on `color_idx` one clock later.
- R11: Once the last pixel of a byte has been held for its full time, the serializer loads the most recently received byte and continues from its first pixel.
- R12: On the clock after any cycle in which `pix_win` is low, `color_idx` is 0.
- R13: The byte given to the serializer is the last `rd_data` captured with `rd_valid` high. Data on cycles without `rd_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_addr | input | ADDR_W | Screen start address, below 0x8000 |
| screen_size | input | ADDR_W | Screen buffer size, subtracted on wrap |
| bytes_per_line | input | BPL_W | Bytes fetched per scanline (80, 40, 20, 10) |
| depth_sel | input | 2 | 0 = 1 bpp, 1 = 2 bpp, 2 = 4 bpp |
| x_scale | input | SCALE_W | Clocks per pixel |
| frame_start | input | 1 | Frame restart pulse |
| line_start | input | 1 | New scanline pulse |
| fetch_win | input | 1 | Fetches are allowed while high |
| pix_win | input | 1 | Pixel output is active while high |
| rd_valid | input | 1 | Marks `rd_data` as a returned byte |
| rd_data | input | 8 | Byte returned from memory |
| fetch_req | output | 1 | One-cycle request for the byte at `fetch_addr` |
| fetch_addr | output | ADDR_W | Address of the next byte to fetch |
| color_idx | output | 4 | Logical colour index of the current pixel |

## Verification
The assertions check four things on every cycle. Each issued request moves the address by one wrapped step of 8. Requests never fall on two adjacent cycles and never point at or above 0x8000. A frame start reloads the start address. The colour index is cleared after a cycle with the pixel window closed. The remaining behaviour can only be shown by the bench's scenarios, because it depends on the memory contents and on many cycles of history. That covers the request spacing tied to the mode, the row-base movement after eight lines, the order of pixels inside each byte, the hold time per pixel, and which returned byte is shown. The bench sweeps every consistent pairing of line width, depth and scale across two character rows, starting close enough to 0x8000 that the wrap happens.

// File: rtl/cellpix_pkg.sv
// Shared helpers for the character-cell pixel path.
// Assumes the depth code is two bits wide; unused codes fall back to 1 bpp.
package cellpix_pkg;

    // Bits per pixel selected by a depth code.
    function automatic logic [2:0] depth_bits(input logic [1:0] sel);
        case (sel)
            2'd1:    depth_bits = 3'd2;
            2'd2:    depth_bits = 3'd4;
            default: depth_bits = 3'd1;
        endcase
    endfunction

    // Index of the last pixel held in one byte for a depth code.
    function automatic logic [2:0] last_pixel(input logic [1:0] sel);
        case (sel)
            2'd1:    last_pixel = 3'd3;
            2'd2:    last_pixel = 3'd1;
            default: last_pixel = 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/cellpix_sched.sv
// Fetch scheduler: decides in which cycles a screen byte is requested.
// Slots are SLOT_CYCLES clocks long. A request is made in the first cycle
// of every (LINE_SLOTS / bytes_per_line)-th slot, counted from the cycle the
// fetch window opens. Assumes bytes_per_line divides LINE_SLOTS.
module cellpix_sched #(
    parameter int SLOT_CYCLES = 8,
    parameter int LINE_SLOTS  = 80,
    parameter int BPL_W       = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BPL_W-1:0] bytes_per_line,
    input  logic             fetch_win,
    output logic             fetch_req
);
    localparam int PH_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;

    logic [PH_W-1:0]  phase;
    logic [BPL_W-1:0] slot_cnt;
    logic [BPL_W-1:0] quot;
    logic [BPL_W-1:0] slots_per_fetch;

    // Number of slots between requests, guarded against zero.
    always_comb begin
        quot = (bytes_per_line == '0) ? BPL_W'(1) : BPL_W'(LINE_SLOTS) / bytes_per_line;
        slots_per_fetch = (quot == '0) ? BPL_W'(1) : quot;
    end

    // Clock phase and slot count, both held at zero while the window is closed.
    always_ff @(posedge clk) begin
        if (!rst_n || !fetch_win) begin
            phase    <= '0;
            slot_cnt <= '0;
        end else if (phase == PH_W'(SLOT_CYCLES - 1)) begin
            phase    <= '0;
            slot_cnt <= (slot_cnt == slots_per_fetch - BPL_W'(1)) ? '0 : slot_cnt + BPL_W'(1);
        end else begin
            phase <= phase + PH_W'(1);
        end
    end

    // A request is made on the first clock of a chosen slot.
    assign fetch_req = fetch_win && (phase == '0) && (slot_cnt == '0);

endmodule

// File: rtl/cellpix_addr.sv
// Address generator for the character-cell layout. Within a line, bytes lie
// CELL_LINES addresses apart. Each line inside a row starts one address after
// the previous line, and each row starts bytes_per_line * CELL_LINES after
// the row before it. Any step that reaches WRAP_LIMIT is pulled back by
// screen_size. Assumes start_addr < WRAP_LIMIT and screen_size is at least
// one row in size.
module cellpix_addr #(
    parameter int ADDR_W     = 16,
    parameter int BPL_W      = 7,
    parameter int CELL_LINES = 8,
    parameter int WRAP_LIMIT = 32'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] screen_size,
    input  logic [BPL_W-1:0]  bytes_per_line,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr
);
    localparam int LN_W = (CELL_LINES > 1) ? $clog2(CELL_LINES) : 1;
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(WRAP_LIMIT);

    logic [ADDR_W-1:0] row_base;
    logic [LN_W-1:0]   line_no;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] row_step;
    logic [ADDR_W-1:0] nxt_row;
    logic [ADDR_W-1:0] nxt_line;
    logic [ADDR_W-1:0] nxt_byte;

    // Bring an address that has run past the buffer end back inside it.
    function automatic logic [ADDR_W-1:0] wrap_back(input logic [ADDR_W-1:0] a,
                                                     input logic [ADDR_W-1:0] size);
        wrap_back = (a >= LIMIT) ? a - size : a;
    endfunction

    // Candidate addresses for next row, next line and next byte.
    always_comb begin
        row_step = ADDR_W'(bytes_per_line) * ADDR_W'(CELL_LINES);
        nxt_row  = wrap_back(row_base + row_step, screen_size);
        nxt_line = wrap_back(row_base + ADDR_W'(line_no) + ADDR_W'(1), screen_size);
        nxt_byte = wrap_back(cur_addr + ADDR_W'(CELL_LINES), screen_size);
    end

    // Row base, line number and current byte address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_base <= '0;
            line_no  <= '0;
            cur_addr <= '0;
        end else if (frame_start) begin
            row_base <= start_addr;
            line_no  <= '0;
            cur_addr <= start_addr;
        end else if (line_start) begin
            if (line_no == LN_W'(CELL_LINES - 1)) begin
                row_base <= nxt_row;
                line_no  <= '0;
                cur_addr <= nxt_row;
            end else begin
                line_no  <= line_no + LN_W'(1);
                cur_addr <= nxt_line;
            end
        end else if (fetch_req) begin
            cur_addr <= nxt_byte;
        end
    end

    assign fetch_addr = cur_addr;

endmodule

// File: rtl/cellpix_serial.sv
// Pixel serializer. Captures each returned byte, and starting from the
// pixel-window edge shifts out pixels MSB-first at the selected depth,
// holding each one for x_scale clocks. Output is registered, so a pixel
// appears one clock after the cycle that selects it. Assumes each returned
// byte arrives before the serializer needs it.
module cellpix_serial #(
    parameter int SCALE_W = 4,
    parameter int COL_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         depth_sel,
    input  logic [SCALE_W-1:0] x_scale,
    input  logic               pix_win,
    input  logic               rd_valid,
    input  logic [7:0]         rd_data,
    output logic [COL_W-1:0]   color_idx
);
    import cellpix_pkg::*;

    logic [7:0]         latest;
    logic [7:0]         shreg;
    logic [2:0]         pix_no;
    logic [SCALE_W-1:0] hold_cnt;
    logic               win_q;
    logic [SCALE_W-1:0] reload;
    logic [2:0]         bits;

    // Hold reload value (0 behaves as 1) and bits per pixel.
    always_comb begin
        reload = (x_scale == '0) ? SCALE_W'(1) : x_scale;
        bits   = depth_bits(depth_sel);
    end

    // Most recent byte returned by memory.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latest <= '0;
        else if (rd_valid)
            latest <= rd_data;
    end

    // Shift register, pixel index and hold counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            pix_no   <= '0;
            hold_cnt <= '0;
            win_q    <= 1'b0;
        end else begin
            win_q <= pix_win;
            if (pix_win && !win_q) begin
                shreg    <= latest;
                pix_no   <= '0;
                hold_cnt <= reload;
            end else if (pix_win) begin
                if (hold_cnt <= SCALE_W'(1)) begin
                    hold_cnt <= reload;
                    if (pix_no == last_pixel(depth_sel)) begin
                        pix_no <= '0;
                        shreg  <= latest;
                    end else begin
                        pix_no <= pix_no + 3'd1;
                        shreg  <= shreg << bits;
                    end
                end else begin
                    hold_cnt <= hold_cnt - SCALE_W'(1);
                end
            end
        end
    end

    // Top bits of the shift register form the colour index inside the window.
    always_comb begin
        color_idx = '0;
        if (win_q) begin
            case (bits)
                3'd2:    color_idx = COL_W'(shreg[7:6]);
                3'd4:    color_idx = COL_W'(shreg[7:4]);
                default: color_idx = COL_W'(shreg[7]);
            endcase
        end
    end

endmodule

// File: rtl/cellpix_fetch.sv
// Top level: character-cell display fetch and pixel serializer.
// Ties together the fetch scheduler, the address generator and the
// serializer. The fetch window must open one slot before the pixel window,
// and memory must answer within one slot.
module cellpix_fetch #(
    parameter int ADDR_W      = 16,
    parameter int BPL_W       = 7,
    parameter int SCALE_W     = 4,
    parameter int SLOT_CYCLES = 8,
    parameter int LINE_SLOTS  = 80,
    parameter int CELL_LINES  = 8,
    parameter int WRAP_LIMIT  = 32'h8000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic [ADDR_W-1:0]  screen_size,
    input  logic [BPL_W-1:0]   bytes_per_line,
    input  logic [1:0]         depth_sel,
    input  logic [SCALE_W-1:0] x_scale,
    input  logic               frame_start,
    input  logic               line_start,
    input  logic               fetch_win,
    input  logic               pix_win,
    input  logic               rd_valid,
    input  logic [7:0]         rd_data,
    output logic               fetch_req,
    output logic [ADDR_W-1:0]  fetch_addr,
    output logic [3:0]         color_idx
);
    logic req_int;

    cellpix_sched #(
        .SLOT_CYCLES (SLOT_CYCLES),
        .LINE_SLOTS  (LINE_SLOTS),
        .BPL_W       (BPL_W)
    ) u_sched (
        .clk            (clk),
        .rst_n          (rst_n),
        .bytes_per_line (bytes_per_line),
        .fetch_win      (fetch_win),
        .fetch_req      (req_int)
    );

    cellpix_addr #(
        .ADDR_W     (ADDR_W),
        .BPL_W      (BPL_W),
        .CELL_LINES (CELL_LINES),
        .WRAP_LIMIT (WRAP_LIMIT)
    ) u_addr (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_addr     (start_addr),
        .screen_size    (screen_size),
        .bytes_per_line (bytes_per_line),
        .frame_start    (frame_start),
        .line_start     (line_start),
        .fetch_req      (req_int),
        .fetch_addr     (fetch_addr)
    );

    cellpix_serial #(
        .SCALE_W (SCALE_W),
        .COL_W   (4)
    ) u_serial (
        .clk       (clk),
        .rst_n     (rst_n),
        .depth_sel (depth_sel),
        .x_scale   (x_scale),
        .pix_win   (pix_win),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .color_idx (color_idx)
    );

    assign fetch_req = req_int;

endmodule

// File: rtl/cellpix_fetch_chk.sv
// Property checker for cellpix_fetch, attached through bind.
// Assumes start_addr stays below WRAP_LIMIT and SLOT_CYCLES is at least 2.
module cellpix_fetch_chk #(
    parameter int ADDR_W     = 16,
    parameter int WRAP_LIMIT = 32'h8000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] start_addr,
    input logic [ADDR_W-1:0] screen_size,
    input logic              frame_start,
    input logic              line_start,
    input logic              pix_win,
    input logic              fetch_req,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [3:0]        color_idx
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(WRAP_LIMIT);

    logic [ADDR_W-1:0] step_sum;
    logic [ADDR_W-1:0] step_exp;

    // Address that a plain byte step is expected to produce.
    always_comb begin
        step_sum = fetch_addr + ADDR_W'(8);
        step_exp = (step_sum >= LIMIT) ? step_sum - screen_size : step_sum;
    end

    // R3
    byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !frame_start && !line_start) |=> (fetch_addr == $past(step_exp)));

    // R4
    addr_below_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (fetch_addr < LIMIT));

    // R2
    req_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> !fetch_req);

    // R7
    frame_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (fetch_addr == $past(start_addr)));

    // R12
    blank_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_win |=> (color_idx == 4'd0));

endmodule

bind cellpix_fetch cellpix_fetch_chk #(
    .ADDR_W     (ADDR_W),
    .WRAP_LIMIT (WRAP_LIMIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_addr  (start_addr),
    .screen_size (screen_size),
    .frame_start (frame_start),
    .line_start  (line_start),
    .pix_win     (pix_win),
    .fetch_req   (fetch_req),
    .fetch_addr  (fetch_addr),
    .color_idx   (color_idx)
);

// File: tb/cellpix_fetch_test.sv
`timescale 1ns/100ps
// Sweep over every consistent (line width, depth, scale) combination.
// Each sweep covers two character rows and starts near 0x8000 so that the
// address wraps.
module cellpix_fetch_test;
    localparam int WIN     = 640;     // window length in clocks
    localparam int T_FETCH = 16;      // fetch window opening cycle in a line
    localparam int T_PIX   = T_FETCH + 8;
    localparam int LINE_LEN = T_PIX + WIN + 4;
    localparam int N_LINES = 10;
    localparam int SIZE    = 16'h2800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] start_addr = '0;
    logic [15:0] screen_size = 16'(SIZE);
    logic [6:0]  bytes_per_line = 7'd80;
    logic [1:0]  depth_sel = '0;
    logic [3:0]  x_scale = 4'd1;
    logic        frame_start = 1'b0;
    logic        line_start = 1'b0;
    logic        fetch_win = 1'b0;
    logic        pix_win = 1'b0;
    logic        rd_valid = 1'b0;
    logic [7:0]  rd_data = '0;
    logic        fetch_req;
    logic [15:0] fetch_addr;
    logic [3:0]  color_idx;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cellpix_fetch uut (
        .clk(clk), .rst_n(rst_n), .start_addr(start_addr), .screen_size(screen_size),
        .bytes_per_line(bytes_per_line), .depth_sel(depth_sel), .x_scale(x_scale),
        .frame_start(frame_start), .line_start(line_start), .fetch_win(fetch_win),
        .pix_win(pix_win), .rd_valid(rd_valid), .rd_data(rd_data),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .color_idx(color_idx)
    );

    function automatic int mem_byte(input int a);
        return ((a & 8'hFF) ^ ((a >> 5) & 8'hFF) ^ 8'hA5) & 8'hFF;
    endfunction

    function automatic int exp_addr(input int st, input int bpl, input int line, input int m);
        int raw;
        raw = st + (line / 8) * bpl * 8 + (line % 8) + 8 * m;
        if (raw >= 32'h8000) raw -= SIZE;
        return raw;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int bpl_l[9]   = '{80, 80, 80, 40, 40, 40, 20, 20, 10};
        int dsel_l[9]  = '{0, 1, 2, 0, 1, 2, 0, 1, 0};
        int scale_l[9] = '{1, 2, 4, 2, 4, 8, 4, 8, 8};
        bit d1_v = 0, d2_v = 0;
        int d1_a = 0, d2_a = 0;
        int exp_col = 0;

        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        check(fetch_req == 1'b0, "R1 fetch_req in reset", fetch_req, 0);
        check(color_idx == 4'd0, "R1 color in reset", color_idx, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(fetch_req == 1'b0, "R1 fetch_req after reset", fetch_req, 0);
        check(color_idx == 4'd0, "R1 color after reset", color_idx, 0);

        for (int c = 0; c < 9; c++) begin
            int bpl, bits, npix, scale, div, st;
            bpl = bpl_l[c]; scale = scale_l[c];
            bits = (dsel_l[c] == 0) ? 1 : (dsel_l[c] == 1) ? 2 : 4;
            npix = 8 / bits;
            div = 80 / bpl;
            st = 16'h7E00 + c * 16'h20;
            @(negedge clk);
            bytes_per_line = 7'(bpl);
            depth_sel = 2'(dsel_l[c]);
            x_scale = 4'(scale);
            start_addr = 16'(st);
            for (int ln = 0; ln < N_LINES; ln++) begin
                for (int j = 0; j < LINE_LEN; j++) begin
                    bit fw, pw, exp_req;
                    if (j > 0) @(negedge clk);
                    fw = (j >= T_FETCH) && (j < T_FETCH + WIN);
                    pw = (j >= T_PIX) && (j < T_PIX + WIN);
                    // R7: line 0 asserts both pulses; frame_start must win
                    frame_start = (j == 0) && (ln == 0);
                    line_start = (j == 0);
                    fetch_win = fw;
                    pix_win = pw;
                    // R13: garbage on rd_data when not valid
                    rd_valid = d2_v;
                    rd_data = d2_v ? 8'(mem_byte(d2_a)) : 8'hFF;
                    #1;
                    // colour resulting from the previous cycle's edge
                    check(color_idx == 4'(exp_col), pw ? "R8 R9 R10 R11 color" : "R12 color",
                          color_idx, exp_col);
                    // R2: request pattern
                    exp_req = fw && (((j - T_FETCH) % (8 * div)) == 0);
                    check(fetch_req == exp_req, "R2 fetch_req", fetch_req, exp_req);
                    if (fetch_req && exp_req) begin
                        int m, ea;
                        string tag;
                        m = (j - T_FETCH) / (8 * div);
                        ea = exp_addr(st, bpl, ln, m);
                        if (ln == 0) tag = "R7 addr";
                        else if (ea < st - 16'h1000) tag = "R4 addr";
                        else if ((ln % 8) == 0 && m == 0) tag = "R6 addr";
                        else if (m == 0) tag = "R5 addr";
                        else tag = "R3 addr";
                        check(fetch_addr == 16'(ea), tag, fetch_addr, ea);
                    end
                    // expected colour after this cycle's edge
                    if (pw) begin
                        int k, b, p, d;
                        k = j - T_PIX;
                        b = k / (scale * npix);
                        p = (k / scale) % npix;
                        d = mem_byte(exp_addr(st, bpl, ln, b));
                        exp_col = (d >> (8 - (p + 1) * bits)) & ((1 << bits) - 1);
                    end else begin
                        exp_col = 0;
                    end
                    d2_v = d1_v; d2_a = d1_a;
                    d1_v = fetch_req; d1_a = fetch_addr;
                end
            end
        end
        frame_start = 1'b0;
        line_start = 1'b0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule